// File: doc/BRIEF.md
# Set/Clear GPIO Control Register

This block holds the control and status of four general-purpose I/O pins in one 32-bit configuration word. Software never writes the pin output data or the output enables directly. Each of the two is changed only through a write-one-to-set field and a write-one-to-clear field. A bit written as 1 in a set field sets the matching pin's state bit, and a 1 in a clear field clears it. Bits written as 0 leave the state alone. Each set and clear field reads back the value last written into it.

A register write takes effect when the write-complete strobe is high at a clock edge. The new pin output data and enables appear on the pin side right after that edge, which is the cycle after the write completes. Each byte lane is qualified by its byte enable. The upper nibble of the word reports the pin levels. Each pin passes through a two-stage synchronizer and is then sampled into the status field, so the field follows a change at a pin after three clock edges.

Top module: `gpio_setclr_reg`

## Requirements
- R1: After reset, pin_out, pin_oe and every bit of reg_rdata are 0. This holds while pin_in is 0.
- R2: A write with reg_be[1] set and a 1 in bit 12+i of reg_wdata makes pin_out[i] high, for pin i from 0 to 3.
- R3: A write with reg_be[1] set and a 1 in bit 8+i of reg_wdata makes pin_out[i] low.
- R4: A write with reg_be[2] set and a 1 in bit 20+i makes pin_oe[i] high. The pin then drives pin_out[i].
- R5: A write with reg_be[2] set and a 1 in bit 16+i makes pin_oe[i] low. The pin is then input-only and is not driven.
- R6: A 0 in any set or clear bit leaves the matching pin_out or pin_oe bit unchanged.
- R7: If a single write has both the set bit and the clear bit of one pin at 1, the clear wins. This applies to both the data fields and the enable fields.
- R8: reg_rdata[15:8] returns the byte last written with reg_be[1] set, and reg_rdata[23:16] returns the byte last written with reg_be[2] set.
- R9: Without reg_be[1], a write changes neither pin_out nor reg_rdata[15:8]. Without reg_be[2], a write changes neither pin_oe nor reg_rdata[23:16].
- R10: reg_rdata[27:24] and reg_rdata[7:0] always read 0. Writes to byte lanes 0 and 3 have no effect.
- R11: reg_rdata[31:28] equals the value pin_in had three clock edges earlier. It does not yet show a change two edges after the change.
- R12: pin_out and pin_oe change only at the clock edge where reg_wr is sampled high. The new values show after that edge. With reg_wr low, the outputs keep their values whatever is on reg_be and reg_wdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write-complete strobe, one cycle per write |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Register read value |
| pin_in | input | 4 | Pin levels from the pads |
| pin_out | output | 4 | Output data to the pad drivers |
| pin_oe | output | 4 | Output enable to the pad drivers, 1 = drive |

## Verification
The bench sweeps every combination of the eight set and clear bits of each field pair, from all sixteen starting states. A design that ignored the set and clear overlap, let set win, or treated a 0 as a clear would give a wrong pin value on some of those combinations. It also tries all sixteen byte-enable patterns. This catches a design that updates a field when its lane is disabled, or that lets the reserved or status lane store data. It steps the pin inputs through every value and samples the status field both two and three edges later. That finds a synchronizer that is one stage short or one stage long. It also holds write data on the bus with the strobe low, to show that the pins move only on a completed write.

// File: rtl/gpio_setclr_pkg.sv
`timescale 1ns/1ps
package gpio_setclr_pkg;
    localparam int unsigned GPIO_N   = 4;
    localparam int unsigned DCLR_LSB = 8;
    localparam int unsigned DSET_LSB = DCLR_LSB + GPIO_N;
    localparam int unsigned ECLR_LSB = DSET_LSB + GPIO_N;
    localparam int unsigned ESET_LSB = ECLR_LSB + GPIO_N;
    localparam int unsigned RSVD_LSB = ESET_LSB + GPIO_N;
    localparam int unsigned PIN_LSB  = RSVD_LSB + GPIO_N;
    localparam int unsigned DAT_LANE = DCLR_LSB / 8;
    localparam int unsigned OE_LANE  = ECLR_LSB / 8;

    typedef logic [GPIO_N-1:0] pinvec_t;

    typedef struct packed {
        pinvec_t dat;
        pinvec_t oe;
        pinvec_t echo_dclr;
        pinvec_t echo_dset;
        pinvec_t echo_eclr;
        pinvec_t echo_eset;
        pinvec_t pin_smp;
    } ctl_state_t;
endpackage

// File: rtl/gpio_setclr_sync.sv
`timescale 1ns/1ps
module gpio_setclr_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d;
    logic [STAGES-1:0][W-1:0] stg_q;

    assign stg_d[0] = din;
    for (genvar i = 1; i < STAGES; i++) begin : g_link
        assign stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_setclr_core.sv
`timescale 1ns/1ps
module gpio_setclr_core
    import gpio_setclr_pkg::*;
#(
    parameter int unsigned REG_W = 32,
    localparam int unsigned BE_W = REG_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [BE_W-1:0]  be,
    input  logic [REG_W-1:0] wdata,
    input  pinvec_t          pin_sync,
    output ctl_state_t       st
);
    ctl_state_t st_d, st_q;
    pinvec_t dclr, dset, eclr, eset;
    logic    dat_hit, oe_hit;

    assign dclr    = wdata[DCLR_LSB +: GPIO_N];
    assign dset    = wdata[DSET_LSB +: GPIO_N];
    assign eclr    = wdata[ECLR_LSB +: GPIO_N];
    assign eset    = wdata[ESET_LSB +: GPIO_N];
    assign dat_hit = wr && be[DAT_LANE];
    assign oe_hit  = wr && be[OE_LANE];

    always_comb begin
        st_d         = st_q;
        st_d.pin_smp = pin_sync;
        if (dat_hit) begin
            st_d.dat       = (st_q.dat | dset) & ~dclr;   // clear wins
            st_d.echo_dclr = dclr;
            st_d.echo_dset = dset;
        end
        if (oe_hit) begin
            st_d.oe        = (st_q.oe | eset) & ~eclr;    // clear wins
            st_d.echo_eclr = eclr;
            st_d.echo_eset = eset;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/gpio_setclr_rdmux.sv
`timescale 1ns/1ps
module gpio_setclr_rdmux
    import gpio_setclr_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input  ctl_state_t       st,
    output logic [REG_W-1:0] rdata
);
    always_comb begin
        rdata                        = '0;
        rdata[DCLR_LSB +: GPIO_N]    = st.echo_dclr;
        rdata[DSET_LSB +: GPIO_N]    = st.echo_dset;
        rdata[ECLR_LSB +: GPIO_N]    = st.echo_eclr;
        rdata[ESET_LSB +: GPIO_N]    = st.echo_eset;
        rdata[PIN_LSB  +: GPIO_N]    = st.pin_smp;
    end
endmodule

// File: rtl/gpio_setclr_reg.sv
`timescale 1ns/1ps
module gpio_setclr_reg
    import gpio_setclr_pkg::*;
#(
    parameter int unsigned REG_W       = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_W/8-1:0]   reg_be,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic [GPIO_N-1:0]    pin_in,
    output logic [GPIO_N-1:0]    pin_out,
    output logic [GPIO_N-1:0]    pin_oe
);
    pinvec_t    pin_sync;
    ctl_state_t st;

    gpio_setclr_sync #(.W(GPIO_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_sync)
    );

    gpio_setclr_core #(.REG_W(REG_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .be       (reg_be),
        .wdata    (reg_wdata),
        .pin_sync (pin_sync),
        .st       (st)
    );

    gpio_setclr_rdmux #(.REG_W(REG_W)) u_rd (
        .st    (st),
        .rdata (reg_rdata)
    );

    assign pin_out = st.dat;
    assign pin_oe  = st.oe;
endmodule

// File: rtl/gpio_setclr_chk.sv
`timescale 1ns/1ps
module gpio_setclr_chk
    import gpio_setclr_pkg::*;
#(
    parameter int unsigned REG_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_W/8-1:0] reg_be,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [GPIO_N-1:0] pin_in,
    input logic [GPIO_N-1:0] pin_out,
    input logic [GPIO_N-1:0] pin_oe
);
    logic [1:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    pinvec_t dset_net, eset_net, dclr_w, eclr_w;
    assign dclr_w   = reg_wdata[DCLR_LSB +: GPIO_N];
    assign eclr_w   = reg_wdata[ECLR_LSB +: GPIO_N];
    assign dset_net = reg_wdata[DSET_LSB +: GPIO_N] & ~dclr_w;
    assign eset_net = reg_wdata[ESET_LSB +: GPIO_N] & ~eclr_w;

    assert_dat_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_be[DAT_LANE]) |=> ((pin_out & $past(dset_net)) == $past(dset_net)));
    assert_dat_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_be[DAT_LANE]) |=> ((pin_out & $past(dclr_w)) == '0));
    assert_oe_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_be[OE_LANE]) |=> ((pin_oe & $past(eset_net)) == $past(eset_net)));
    assert_oe_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_be[OE_LANE]) |=> ((pin_oe & $past(eclr_w)) == '0));
    assert_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_be[DAT_LANE]) |=> $stable(pin_out));
    assert_rsvd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[RSVD_LSB +: GPIO_N] == '0) && (reg_rdata[7:0] == '0));
    assert_pin_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 2'd3) |-> (reg_rdata[PIN_LSB +: GPIO_N] == $past(pin_in, 3)));
    assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_setclr_reg gpio_setclr_chk #(.REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_setclr_reg_test.sv
`timescale 1ns/1ps
module gpio_setclr_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  pin_in = '0;
    logic [3:0]  pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] m_dat = '0, m_oe = '0, m_ecd = '0, m_esd = '0, m_ece = '0, m_ese = '0, m_in = '0;

    always #10 clk = ~clk;

    gpio_setclr_reg uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd();
        return {m_in, 4'h0, m_ese, m_ece, m_esd, m_ecd, 8'h00};
    endfunction

    task automatic model_apply(input logic [3:0] be, input logic [31:0] wd);
        if (be[1]) begin
            m_dat = (m_dat | wd[15:12]) & ~wd[11:8];
            m_ecd = wd[11:8];
            m_esd = wd[15:12];
        end
        if (be[2]) begin
            m_oe  = (m_oe | wd[23:20]) & ~wd[19:16];
            m_ece = wd[19:16];
            m_ese = wd[23:20];
        end
    endtask

    // Drives one write; before the capturing edge the pins must still show the old state (R12).
    task automatic do_write(input logic [3:0] be, input logic [31:0] wd);
        @(negedge clk);
        reg_wr = 1'b1; reg_be = be; reg_wdata = wd;
        #1;
        chk("R12", {24'h0, pin_oe, pin_out}, {24'h0, m_oe, m_dat});
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
        model_apply(be, wd);
    endtask

    function automatic string tag_of(input logic [3:0] s, input logic [3:0] c,
                                     input string ts, input string tc);
        if ((s & c) != 0) return "R7";
        if (s != 0)       return ts;
        if (c != 0)       return tc;
        return "R6";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {24'h0, pin_oe, pin_out}, 32'h0);
        chk("R1", reg_rdata, 32'h0);

        // Data fields: every start state x every set/clear byte
        for (int s0 = 0; s0 < 16; s0++) begin
            for (int v = 0; v < 256; v++) begin
                logic [3:0] st, sv, cv;
                st = 4'(s0); sv = 4'(v >> 4); cv = 4'(v);
                do_write(4'b0010, {16'h0, st, ~st, 8'h0});
                do_write(4'b0010, {16'h0, sv, cv, 8'h0});
                chk(tag_of(sv, cv, "R2", "R3"), {28'h0, pin_out}, {28'h0, m_dat});
                chk("R8", reg_rdata, exp_rd());
            end
        end

        // Enable fields: same sweep
        for (int s0 = 0; s0 < 16; s0++) begin
            for (int v = 0; v < 256; v++) begin
                logic [3:0] st, sv, cv;
                st = 4'(s0); sv = 4'(v >> 4); cv = 4'(v);
                do_write(4'b0100, {8'h0, st, ~st, 16'h0});
                do_write(4'b0100, {8'h0, sv, cv, 16'h0});
                chk(tag_of(sv, cv, "R4", "R5"), {28'h0, pin_oe}, {28'h0, m_oe});
                chk("R8", reg_rdata, exp_rd());
            end
        end

        // Byte-lane sweep
        for (int b = 0; b < 16; b++) begin
            do_write(4'b0110, 32'h00_5A_5A_00);
            do_write(4'(b), 32'h5A_C3_3C_A5);
            chk("R9", {24'h0, pin_oe, pin_out}, {24'h0, m_oe, m_dat});
            chk("R9", reg_rdata, exp_rd());
            chk("R10", reg_rdata & 32'h0F00_00FF, 32'h0);
        end

        // Strobe low: bus activity ignored
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            reg_be = 4'hF; reg_wdata = (k % 2 == 0) ? 32'h00F0_F000 : 32'h000F_0F00;
            @(negedge clk);
            chk("R12", {24'h0, pin_oe, pin_out}, {24'h0, m_oe, m_dat});
            chk("R12", reg_rdata, exp_rd());
            reg_be = '0; reg_wdata = '0;
        end

        // Pin input latency
        for (int p = 1; p <= 16; p++) begin
            logic [3:0] nv;
            nv = 4'(p ^ (p >> 1));
            @(negedge clk);
            pin_in = nv;
            @(negedge clk);
            @(negedge clk);
            chk("R11", reg_rdata, exp_rd());
            m_in = nv;
            @(negedge clk);
            chk("R11", reg_rdata, exp_rd());
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule